// File: doc/BRIEF.md
# Free-Running 16-bit Timer with Coherent Byte Reads

This block is a 16-bit up-counter that runs continuously and is read and configured over an 8-bit register bus. Because the bus is one byte wide, a read of the upper byte captures the lower byte into a buffer. The following low-byte read then returns a value that belongs to the same count, even if the counter has moved in between. A second low-byte register gives the same data path for the sequence. Outside a sequence it returns the live count, and no access to it ever disturbs the overflow flag. Software can therefore sample elapsed time freely while overflow handling runs alongside.

When the counter wraps, an overflow flag is set. The flag drives an interrupt request, gated by an enable bit and a global mask input. The flag is cleared in two steps: a status read while the flag is set, then a read or write of the main low-byte register. If the counter overflows again between the two steps, the second step does not clear the flag. The count advances either from a prescaled system clock (divide by 2, 4 or 8) or from an external pin. The pin is synchronised to the system clock, and a control bit selects whether its rising or its falling edge counts. A halt input freezes counting.

Register map (3-bit address): 0 count high, 1 main count low, 2 alternate count high, 3 alternate count low, 4 status (bit 7 = overflow flag), 5 control 1 (bit 7 = overflow interrupt enable), 6 control 2 (bits 1:0 = clock select, bit 2 = edge select). Reads of unused addresses return 0, and writes to read-only registers have no effect.

Top module: `frt16_timer`

## Requirements
- R1: After reset the count is FFFFh-3 (FFFCh), the overflow flag is 0, control 1 and control 2 read 00h, and `irq` is 0.
- R2: A read of address 0 or 2 returns count bits 15:8 and captures count bits 7:0. The next read of address 1 or 3 returns the captured byte and ends the sequence.
- R3: Further reads of address 0 or 2 while a sequence is open do not re-capture the low byte.
- R4: With no sequence open, reads of address 1 or 3 return the live count bits 7:0.
- R5: When control 2 bits 1:0 are 00, 01 or 10, the count advances once every 2, 4 or 8 system clocks respectively.
- R6: When control 2 bits 1:0 are 11, each edge of `ext_pin` advances the count by one: rising edges when control 2 bit 2 is 1, falling edges when it is 0. Edges of the other polarity have no effect.
- R7: While `halt` is 1 the count holds its value, and counting resumes from that value when `halt` falls. A reset during halt restarts the count from FFFCh.
- R8: A wrap from FFFFh to 0000h sets status bit 7.
- R9: `irq` is 1 exactly when status bit 7 is 1, control 1 bit 7 is 1 and `irq_mask` is 0. A pending flag raises `irq` as soon as the gating allows it.
- R10: The flag is cleared by a status read while it is set, followed by a read or write of address 1. An access to address 1 without that prior status read does not clear it. A write to address 1 does not change the count.
- R11: Reads or writes of address 3 never clear the flag.
- R12: An overflow that occurs after the status read and before the address-1 access cancels that status read. The flag then stays set after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes counting while 1 |
| ext_pin | input | 1 | External count source, asynchronous |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks `irq` |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the access cycle |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that at most one register is accessed per cycle, with the address qualified by `bus_sel`. They also assume that `ext_pin` is low when reset is released and holds each level for several system clocks, so the synchroniser never sees a runt pulse. The bench drives every input on the falling clock edge. It holds each external pin level for at least four cycles and releases reset with the pin low. Every bus access lasts exactly one cycle, so the assumptions hold for the whole run.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned CNT_W = 2 * BUS_W;
  localparam int unsigned PRE_W = 3;

  localparam logic [2:0] A_CNT_HI = 3'd0;
  localparam logic [2:0] A_CNT_LO = 3'd1;
  localparam logic [2:0] A_ALT_HI = 3'd2;
  localparam logic [2:0] A_ALT_LO = 3'd3;
  localparam logic [2:0] A_STAT   = 3'd4;
  localparam logic [2:0] A_CTRL1  = 3'd5;
  localparam logic [2:0] A_CTRL2  = 3'd6;

  localparam logic [1:0] SRC_EXT = 2'b11;

  // Prescaler tick: low 1, 2 or 3 phase bits all ones.
  function automatic logic div_tick(input logic [PRE_W-1:0] ph, input logic [1:0] sel);
    case (sel)
      2'b00:   return ph[0];
      2'b01:   return &ph[1:0];
      default: return &ph;
    endcase
  endfunction

  // Count value after one step (wraps modulo 2^CNT_W).
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/frt_clk_src.sv
module frt_clk_src
  import frt_pkg::*;
#(
  parameter int unsigned SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       ext_pin,
  input  logic [1:0] clk_sel,
  input  logic       rise_sel,
  output logic       cnt_en
);
  logic [PRE_W-1:0] ph_q;
  logic [SYNC_N:0]  sh_q;
  logic lvl_now, lvl_prev, ext_edge, int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[SYNC_N-1:0], ext_pin};
      if (!halt) ph_q <= ph_q + 1'b1;
    end
  end

  always_comb begin
    lvl_now  = sh_q[SYNC_N-1];
    lvl_prev = sh_q[SYNC_N];
    ext_edge = rise_sel ? (lvl_now & ~lvl_prev) : (~lvl_now & lvl_prev);
    int_tick = div_tick(ph_q, clk_sel);
    cnt_en   = ~halt & ((clk_sel == SRC_EXT) ? ext_edge : int_tick);
  end
endmodule

// File: rtl/frt_counter.sv
module frt_counter
  import frt_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_CNT = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= RESET_CNT;
    else if (cnt_en) cnt <= step_count(cnt);
  end

  assign wrap_evt = cnt_en & (&cnt);
endmodule

// File: rtl/frt_read_latch.sv
module frt_read_latch
  import frt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_rd,
  input  logic             lo_rd,
  input  logic [BUS_W-1:0] live_lo,
  output logic [BUS_W-1:0] lo_data,
  output logic [BUS_W-1:0] lo_latch,
  output logic             seq_open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_latch <= '0;
      seq_open <= 1'b0;
    end else if (lo_rd) begin
      seq_open <= 1'b0;
    end else if (hi_rd && !seq_open) begin
      lo_latch <= live_lo;
      seq_open <= 1'b1;
    end
  end

  assign lo_data = seq_open ? lo_latch : live_lo;
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic stat_rd,
  input  logic main_lo_acc,
  output logic flag,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (wrap_evt) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (armed && main_lo_acc) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (stat_rd && flag) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/frt16_timer.sv
module frt16_timer
  import frt_pkg::*;
#(
  parameter logic [15:0] RESET_CNT = 16'hFFFC,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       ext_pin,
  input  logic       irq_mask,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  logic             ovf_ie;
  logic [1:0]       clk_sel;
  logic             rise_sel;
  logic             cnt_en, wrap_evt;
  logic [CNT_W-1:0] cnt_q;
  logic             hi_rd, lo_rd, stat_rd, main_lo_acc, alt_lo_acc;
  logic [BUS_W-1:0] lo_data, lo_latch;
  logic             seq_open, ovf_flag, ovf_armed;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[6:3];

  // Bus decode: one access per cycle.
  assign hi_rd       = bus_sel & ~bus_wr & ((bus_addr == A_CNT_HI) | (bus_addr == A_ALT_HI));
  assign lo_rd       = bus_sel & ~bus_wr & ((bus_addr == A_CNT_LO) | (bus_addr == A_ALT_LO));
  assign stat_rd     = bus_sel & ~bus_wr & (bus_addr == A_STAT);
  assign main_lo_acc = bus_sel & (bus_addr == A_CNT_LO);
  assign alt_lo_acc  = bus_sel & (bus_addr == A_ALT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_ie   <= 1'b0;
      clk_sel  <= 2'b00;
      rise_sel <= 1'b0;
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == A_CTRL1) ovf_ie <= bus_wdata[7];
      if (bus_addr == A_CTRL2) begin
        clk_sel  <= bus_wdata[1:0];
        rise_sel <= bus_wdata[2];
      end
    end
  end

  frt_clk_src #(.SYNC_N(SYNC_N)) u_src (
    .clk(clk), .rst_n(rst_n), .halt(halt), .ext_pin(ext_pin),
    .clk_sel(clk_sel), .rise_sel(rise_sel), .cnt_en(cnt_en)
  );

  frt_counter #(.RESET_CNT(RESET_CNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt(cnt_q), .wrap_evt(wrap_evt)
  );

  frt_read_latch u_latch (
    .clk(clk), .rst_n(rst_n), .hi_rd(hi_rd), .lo_rd(lo_rd),
    .live_lo(cnt_q[BUS_W-1:0]), .lo_data(lo_data), .lo_latch(lo_latch), .seq_open(seq_open)
  );

  frt_ovf_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .stat_rd(stat_rd),
    .main_lo_acc(main_lo_acc), .flag(ovf_flag), .armed(ovf_armed)
  );

  always_comb begin
    case (bus_addr)
      A_CNT_HI, A_ALT_HI: bus_rdata = cnt_q[CNT_W-1:BUS_W];
      A_CNT_LO, A_ALT_LO: bus_rdata = lo_data;
      A_STAT:             bus_rdata = {ovf_flag, 7'b0};
      A_CTRL1:            bus_rdata = {ovf_ie, 7'b0};
      A_CTRL2:            bus_rdata = {5'b0, rise_sel, clk_sel};
      default:            bus_rdata = '0;
    endcase
  end

  assign irq = ovf_flag & ovf_ie & ~irq_mask;
endmodule

// File: rtl/frt16_timer_chk.sv
module frt16_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        halt,
  input logic        irq_mask,
  input logic        irq,
  input logic [15:0] cnt,
  input logic        wrap_evt,
  input logic        flag,
  input logic        armed,
  input logic        seq_open,
  input logic [7:0]  lo_latch,
  input logic        alt_acc
);
  // R8
  wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag);

  // R12
  wrap_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> !armed);

  // R10
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed));

  // R11
  alt_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_acc && flag) |=> flag);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && !irq_mask));

  // R7
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(cnt));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 16'd1));

  // R3
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_open && $past(seq_open)) |-> $stable(lo_latch));
endmodule

bind frt16_timer frt16_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .irq_mask(irq_mask), .irq(irq),
  .cnt(cnt_q), .wrap_evt(wrap_evt), .flag(ovf_flag), .armed(ovf_armed),
  .seq_open(seq_open), .lo_latch(lo_latch), .alt_acc(alt_lo_acc)
);

// File: tb/tb_frt16_timer.sv
module tb_frt16_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt = 1'b1;
  logic       ext_pin = 1'b0;
  logic       irq_mask = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  logic [7:0]  a, b, h0, l0, d;
  logic [15:0] c1;

  frt16_timer dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .ext_pin(ext_pin), .irq_mask(irq_mask),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] ad, output logic [7:0] dv);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ad;
    #1 dv = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [2:0] ad, input logic [7:0] dv);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad; bus_wdata = dv;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pin_level(input logic v);
    @(negedge clk);
    ext_pin = v;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    rd(3'd0, d); chk("R1 hi", {8'h0, d}, 16'h00FF);
    rd(3'd3, d); chk("R1 lo", {8'h0, d}, 16'h00FC);
    rd(3'd4, d); chk("R1 stat", {8'h0, d}, 16'h0000);
    rd(3'd5, d); chk("R1 ctrl1", {8'h0, d}, 16'h0000);
    rd(3'd6, d); chk("R1 ctrl2", {8'h0, d}, 16'h0000);
    chk("R1 irq", {15'h0, irq}, 16'h0000);

    // R5 prescaler sweep: 48 clocks give 48/div steps
    @(negedge clk); halt = 1'b0;
    for (int s = 0; s < 3; s++) begin
      wr(3'd6, 8'(s));
      rd(3'd3, a);
      repeat (47) @(posedge clk);
      rd(3'd3, b);
      chk("R5 divide", {8'h0, 8'(b - a)}, 16'(48 >> (s + 1)));
    end

    // R7 halt freezes
    @(negedge clk); halt = 1'b1;
    rd(3'd3, a);
    repeat (20) @(posedge clk);
    rd(3'd3, b);
    chk("R7 halt hold", {8'h0, b}, {8'h0, a});

    // R2 R3 R4 coherent read with /8 clock
    wr(3'd6, 8'h02);
    rd(3'd3, l0);
    rd(3'd0, h0);
    @(negedge clk); halt = 1'b0;
    repeat (96) @(posedge clk);
    #1 halt = 1'b1;
    c1 = {h0, l0} + 16'd12;
    rd(3'd2, d); chk("R2 hi live", {8'h0, d}, {8'h0, c1[15:8]});
    rd(3'd0, d); chk("R3 hi again", {8'h0, d}, {8'h0, c1[15:8]});
    rd(3'd1, d); chk("R3 latched lo", {8'h0, d}, {8'h0, l0});
    rd(3'd1, d); chk("R4 live main", {8'h0, d}, {8'h0, c1[7:0]});
    rd(3'd3, d); chk("R4 live alt", {8'h0, d}, {8'h0, c1[7:0]});
    rd(3'd2, h0);
    rd(3'd3, d); chk("R2 alt pair", {h0, d}, c1);

    // R7 reset while halted restarts
    do_reset();
    rd(3'd0, h0); rd(3'd1, d);
    chk("R7 reset restart", {h0, d}, 16'hFFFC);

    // R6 external rising edges
    wr(3'd6, 8'h07);
    @(negedge clk); halt = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      pin_level(1'b1);
      pin_level(1'b0);
      rd(3'd3, d); chk("R6 rising step", {8'h0, d}, 16'(8'hFC + k));
    end
    // R6 falling edge select: a rise alone does nothing
    wr(3'd6, 8'h03);
    pin_level(1'b1);
    rd(3'd3, d); chk("R6 rise ignored", {8'h0, d}, 16'h00FF);
    // R9 gating with enable off: flag pending, no irq
    pin_level(1'b0);
    rd(3'd0, h0); rd(3'd1, d);
    chk("R6 falling wrap", {h0, d}, 16'h0000);
    chk("R9 irq disabled", {15'h0, irq}, 16'h0000);
    rd(3'd4, d); chk("R8 flag set", {8'h0, d}, 16'h0080);
    // flag is now armed by that status read (R12 setup)
    @(negedge clk); irq_mask = 1'b1;
    wr(3'd5, 8'h80);
    #1 chk("R9 masked", {15'h0, irq}, 16'h0000);
    @(negedge clk); irq_mask = 1'b0;
    #1 chk("R9 pending fires", {15'h0, irq}, 16'h0001);

    // R12 new overflow between the two steps cancels arming
    wr(3'd6, 8'h00);
    repeat (131100) @(posedge clk);
    #1 halt = 1'b1;
    wr(3'd1, 8'h00);
    #1 chk("R12 cancelled clear", {15'h0, irq}, 16'h0001);

    // R10 access without status read keeps flag; write leaves count
    rd(3'd3, a);
    wr(3'd1, 8'h55);
    #1 chk("R10 no arm", {15'h0, irq}, 16'h0001);
    rd(3'd3, b); chk("R10 write ignored", {8'h0, b}, {8'h0, a});

    // R11 alternate accesses after arming keep flag
    rd(3'd4, d);
    rd(3'd3, d);
    wr(3'd3, 8'hAA);
    #1 chk("R11 alt keeps flag", {15'h0, irq}, 16'h0001);
    rd(3'd3, d); chk("R11 alt write ignored", {8'h0, d}, {8'h0, a});

    // R10 completing the sequence with a read clears
    rd(3'd1, d);
    #1 chk("R10 cleared irq", {15'h0, irq}, 16'h0000);
    rd(3'd4, d); chk("R10 cleared stat", {8'h0, d}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule